// File: doc/BRIEF.md
# Interrupt Frame Push/Pop Sequencer

This block saves and restores processor context around an interrupt. When the core accepts an interrupt, the block writes a two-word frame to a data stack. The frame holds the 23-bit program counter and the status low byte. The block then raises the priority in the status register to the level of the interrupt just taken.

On a return command the block reads the frame back in the reverse order. It restores the status low byte and the priority-extension bit, and it presents the saved program counter to the core. The stack grows upward: a push writes at the pointer and then moves it up, and a pop moves the pointer down first and then reads. Software may overwrite the status low byte at any cycle through a plain write strobe.

Stack memory is reached through one word-wide request channel that uses valid/ready:
- The block raises `mem_valid` together with `mem_we`, `mem_addr` and, for a write, `mem_wdata`.
- These values stay unchanged until a cycle in which `mem_ready` is high. That cycle completes the transfer.
- For a read, `mem_rdata` must be valid in that same cycle.
- The memory may hold `mem_ready` low for any number of cycles. While it does, neither the pointer nor the sequence advances.

Top module: `irq_frame_seq`

## Requirements
- R1: After reset, `sp` equals SP_RESET (default 0x0800), `sr_low` is 0x00, `ipl3` is 0, and `busy`, `entry_done`, `ret_done` and `mem_valid` are all low.
- R2: An accepted entry makes two writes in this order. The first writes PC[15:0] at address `sp`. The second writes at `sp`+2. After each write completes, `sp` grows by 2, so it ends 4 higher.
- R3: The second frame word has this layout. Bits 15:8 hold the status low byte and bit 7 holds the `ipl3` value, both as they were in the cycle the entry was accepted. Bits 6:0 hold PC[22:16].
- R4: The cycle after the final write of an entry completes, `entry_done` is high for exactly one cycle and `busy` is low. In the same cycle `sr_low[7:5]` equals `entry_level[2:0]` and `ipl3` equals `entry_level[3]`, while `sr_low[4:0]` keeps its value. A level of 8 or above is a trap; a level below 8 leaves `ipl3` clear.
- R5: An accepted return makes two reads in this order. The first reads address `sp`-2 and the second reads `sp`-4. After each read completes, `sp` falls by 2. The cycle after the second read completes, `ret_done` pulses for one cycle. In that cycle `ret_pc` is {first word[6:0], second word}, `sr_low` is first word[15:8] and `ipl3` is first word[7].
- R6: Nested entries followed by the same number of returns give back each saved PC and status in last-in-first-out order, and `sp` returns to its starting value.
- R7: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_we`, `mem_addr` and `mem_wdata` hold their values and `sp` does not change.
- R8: A software write (`sw_sr_we`) replaces `sr_low` in the next cycle, whether or not the block is busy. If the block loads the status in that same cycle (the final transfer of an entry or a return), the load takes precedence over the software write.
- R9: `entry_req` and `ret_req` are ignored while `busy` is high. When both are high in an idle cycle, the entry is taken and the return is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| entry_req | input | 1 | Take an interrupt (sampled while idle) |
| entry_level | input | 4 | New priority; bit 3 set marks a trap |
| entry_pc | input | 23 | Program counter to save |
| ret_req | input | 1 | Return from interrupt (sampled while idle) |
| sw_sr_we | input | 1 | Software write strobe for the status low byte |
| sw_sr_data | input | 8 | Software write data |
| busy | output | 1 | A push or pop sequence is in progress |
| entry_done | output | 1 | One-cycle pulse when an entry completes |
| ret_done | output | 1 | One-cycle pulse when a return completes |
| ret_pc | output | 23 | Restored program counter |
| sr_low | output | 8 | Status low byte; bits 7:5 hold the priority |
| ipl3 | output | 1 | Priority-extension bit |
| sp | output | SP_W | Stack pointer (byte address) |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts or returns this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | SP_W | Word address in bytes |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid while `mem_ready` is high |

## Verification
The main path runs through a table of four nested entries followed by four returns. The vectors vary the PC bit patterns, the status bytes and the priority levels. One level is a trap, so a later frame must carry `ipl3`=1. This is how a swapped or misplaced field in the second frame word is exposed. Half the vectors run against a memory that alternates `mem_ready`, and half against one that is always ready. This separates correct hold-under-back-pressure from a sequence that advances on `mem_valid` alone. Directed cases cover the following:
- a software write while busy;
- a software write that collides with the final load;
- requests pulsed while busy;
- both requests arriving in the same idle cycle.

// File: rtl/irq_frame_pkg.sv
package irq_frame_pkg;

  localparam int unsigned PC_W     = 23;
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned SR_W     = 8;
  localparam int unsigned LVL_W    = 4;
  localparam int unsigned IPL_LSB  = 5;
  localparam int unsigned IPL_W    = 3;
  localparam int unsigned PCHI_W   = PC_W - WORD_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_LO,
    ST_PUSH_HI,
    ST_POP_HI,
    ST_POP_LO
  } seq_state_e;

  // Upper frame word: {status byte, extension bit, pc high bits}
  function automatic logic [WORD_W-1:0] pack_hi(
    input logic [SR_W-1:0] sr,
    input logic            ext,
    input logic [PC_W-1:0] pc
  );
    return {sr, ext, pc[PC_W-1:WORD_W]};
  endfunction

  function automatic logic [SR_W-1:0] hi_sr(input logic [WORD_W-1:0] w);
    return w[WORD_W-1 -: SR_W];
  endfunction

  function automatic logic hi_ext(input logic [WORD_W-1:0] w);
    return w[PCHI_W];
  endfunction

  function automatic logic [PCHI_W-1:0] hi_pc(input logic [WORD_W-1:0] w);
    return w[PCHI_W-1:0];
  endfunction

endpackage

// File: rtl/irq_sp_unit.sv
module irq_sp_unit #(
  parameter int unsigned    SP_W     = 16,
  parameter logic [SP_W-1:0] SP_RESET = 16'h0800,
  parameter int unsigned    STEP     = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inc,
  input  logic            dec,
  output logic [SP_W-1:0] sp,
  output logic [SP_W-1:0] push_addr,
  output logic [SP_W-1:0] pop_addr
);

  localparam logic [SP_W-1:0] STEP_V = SP_W'(STEP);

  logic [SP_W-1:0] sp_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   sp_q <= SP_RESET;
    else if (inc) sp_q <= sp_q + STEP_V;
    else if (dec) sp_q <= sp_q - STEP_V;
  end

  assign sp        = sp_q;
  assign push_addr = sp_q;
  assign pop_addr  = sp_q - STEP_V;

  AST_SP_ONE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc && dec));                                               // R7
  AST_SP_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> sp == $past(sp) + STEP_V);                            // R2
  AST_SP_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    dec |=> sp == $past(sp) - STEP_V);                            // R5

endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_frame_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_we,
  input  logic [SR_W-1:0]  sw_data,
  input  logic             ld_entry,
  input  logic [LVL_W-1:0] entry_level,
  input  logic             ld_ret,
  input  logic [SR_W-1:0]  ret_sr,
  input  logic             ret_ext,
  output logic [SR_W-1:0]  sr,
  output logic             ext
);

  logic [SR_W-1:0] sr_q;
  logic            ext_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q  <= '0;
      ext_q <= 1'b0;
    end else if (ld_entry) begin
      sr_q[IPL_LSB +: IPL_W] <= entry_level[IPL_W-1:0];
      ext_q                  <= entry_level[LVL_W-1];
    end else if (ld_ret) begin
      sr_q  <= ret_sr;
      ext_q <= ret_ext;
    end else if (sw_we) begin
      sr_q  <= sw_data;
    end
  end

  assign sr  = sr_q;
  assign ext = ext_q;

  AST_ENTRY_LOADS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    ld_entry |=> (sr[IPL_LSB +: IPL_W] == $past(entry_level[IPL_W-1:0]))
                 && (ext == $past(entry_level[LVL_W-1])));        // R4
  AST_ENTRY_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_entry |=> sr[IPL_LSB-1:0] == $past(sr[IPL_LSB-1:0]));      // R4
  AST_SW_WRITE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_we && !ld_entry && !ld_ret) |=> sr == $past(sw_data));    // R8
  AST_RET_OVER_SW: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ret |=> (sr == $past(ret_sr)) && (ext == $past(ret_ext))); // R8

endmodule

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_frame_pkg::*;
#(
  parameter int unsigned SP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              entry_req,
  input  logic [LVL_W-1:0]  entry_level,
  input  logic [PC_W-1:0]   entry_pc,
  input  logic              ret_req,
  input  logic [SR_W-1:0]   cur_sr,
  input  logic              cur_ext,
  input  logic [SP_W-1:0]   push_addr,
  input  logic [SP_W-1:0]   pop_addr,
  output logic              sp_inc,
  output logic              sp_dec,
  output logic              ld_entry,
  output logic [LVL_W-1:0]  ld_level,
  output logic              ld_ret,
  output logic [SR_W-1:0]   ret_sr,
  output logic              ret_ext,
  output logic              busy,
  output logic              entry_done,
  output logic              ret_done,
  output logic [PC_W-1:0]   ret_pc,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [SP_W-1:0]   mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata
);

  seq_state_e        state_q, state_d;
  logic [PC_W-1:0]   pc_q;
  logic [LVL_W-1:0]  lvl_q;
  logic [SR_W-1:0]   snap_sr_q;
  logic              snap_ext_q;
  logic [WORD_W-1:0] hold_q;
  logic [PC_W-1:0]   ret_pc_q;
  logic              entry_done_q, ret_done_q;
  logic              idle, take_entry, take_ret, xfer;

  assign idle       = (state_q == ST_IDLE);
  assign take_entry = idle && entry_req;
  assign take_ret   = idle && ret_req && !entry_req;
  assign xfer       = mem_valid && mem_ready;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (take_entry)    state_d = ST_PUSH_LO;
        else if (take_ret) state_d = ST_POP_HI;
      end
      ST_PUSH_LO: if (xfer) state_d = ST_PUSH_HI;
      ST_PUSH_HI: if (xfer) state_d = ST_IDLE;
      ST_POP_HI:  if (xfer) state_d = ST_POP_LO;
      ST_POP_LO:  if (xfer) state_d = ST_IDLE;
      default:              state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      pc_q         <= '0;
      lvl_q        <= '0;
      snap_sr_q    <= '0;
      snap_ext_q   <= 1'b0;
      hold_q       <= '0;
      ret_pc_q     <= '0;
      entry_done_q <= 1'b0;
      ret_done_q   <= 1'b0;
    end else begin
      state_q      <= state_d;
      entry_done_q <= xfer && (state_q == ST_PUSH_HI);
      ret_done_q   <= xfer && (state_q == ST_POP_LO);
      if (take_entry) begin
        pc_q       <= entry_pc;
        lvl_q      <= entry_level;
        snap_sr_q  <= cur_sr;
        snap_ext_q <= cur_ext;
      end
      if (xfer && state_q == ST_POP_HI) hold_q <= mem_rdata;
      if (xfer && state_q == ST_POP_LO) ret_pc_q <= {hi_pc(hold_q), mem_rdata};
    end
  end

  always_comb begin
    mem_valid = 1'b0;
    mem_we    = 1'b0;
    mem_wdata = '0;
    unique case (state_q)
      ST_PUSH_LO: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = pc_q[WORD_W-1:0];
      end
      ST_PUSH_HI: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = pack_hi(snap_sr_q, snap_ext_q, pc_q);
      end
      ST_POP_HI, ST_POP_LO: mem_valid = 1'b1;
      default: ;
    endcase
  end

  assign mem_addr   = mem_we ? push_addr : pop_addr;
  assign sp_inc     = xfer && mem_we;
  assign sp_dec     = xfer && !mem_we;
  assign ld_entry   = xfer && (state_q == ST_PUSH_HI);
  assign ld_level   = lvl_q;
  assign ld_ret     = xfer && (state_q == ST_POP_LO);
  assign ret_sr     = hi_sr(hold_q);
  assign ret_ext    = hi_ext(hold_q);
  assign busy       = !idle;
  assign entry_done = entry_done_q;
  assign ret_done   = ret_done_q;
  assign ret_pc     = ret_pc_q;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> mem_valid && $stable(mem_we)
      && $stable(mem_addr) && $stable(mem_wdata));                // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_done || ret_done) |-> !busy);                          // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    entry_done |=> !entry_done);                                  // R4
  AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(entry_done && ret_done));                                   // R9
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_valid) |-> 1'b0);                               // R9

endmodule

// File: rtl/irq_frame_seq.sv
module irq_frame_seq
  import irq_frame_pkg::*;
#(
  parameter int unsigned     SP_W     = 16,
  parameter logic [SP_W-1:0] SP_RESET = 16'h0800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              entry_req,
  input  logic [LVL_W-1:0]  entry_level,
  input  logic [PC_W-1:0]   entry_pc,
  input  logic              ret_req,
  input  logic              sw_sr_we,
  input  logic [SR_W-1:0]   sw_sr_data,
  output logic              busy,
  output logic              entry_done,
  output logic              ret_done,
  output logic [PC_W-1:0]   ret_pc,
  output logic [SR_W-1:0]   sr_low,
  output logic              ipl3,
  output logic [SP_W-1:0]   sp,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [SP_W-1:0]   mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata
);

  localparam int unsigned STEP = WORD_W / 8;

  logic              sp_inc, sp_dec;
  logic [SP_W-1:0]   push_addr, pop_addr;
  logic              ld_entry, ld_ret, ret_ext;
  logic [LVL_W-1:0]  ld_level;
  logic [SR_W-1:0]   ret_sr;

  irq_sp_unit #(
    .SP_W     (SP_W),
    .SP_RESET (SP_RESET),
    .STEP     (STEP)
  ) i_sp (
    .clk       (clk),
    .rst_n     (rst_n),
    .inc       (sp_inc),
    .dec       (sp_dec),
    .sp        (sp),
    .push_addr (push_addr),
    .pop_addr  (pop_addr)
  );

  irq_status_unit i_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_we       (sw_sr_we),
    .sw_data     (sw_sr_data),
    .ld_entry    (ld_entry),
    .entry_level (ld_level),
    .ld_ret      (ld_ret),
    .ret_sr      (ret_sr),
    .ret_ext     (ret_ext),
    .sr          (sr_low),
    .ext         (ipl3)
  );

  irq_seq_ctrl #(
    .SP_W (SP_W)
  ) i_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .entry_req   (entry_req),
    .entry_level (entry_level),
    .entry_pc    (entry_pc),
    .ret_req     (ret_req),
    .cur_sr      (sr_low),
    .cur_ext     (ipl3),
    .push_addr   (push_addr),
    .pop_addr    (pop_addr),
    .sp_inc      (sp_inc),
    .sp_dec      (sp_dec),
    .ld_entry    (ld_entry),
    .ld_level    (ld_level),
    .ld_ret      (ld_ret),
    .ret_sr      (ret_sr),
    .ret_ext     (ret_ext),
    .busy        (busy),
    .entry_done  (entry_done),
    .ret_done    (ret_done),
    .ret_pc      (ret_pc),
    .mem_valid   (mem_valid),
    .mem_ready   (mem_ready),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_rdata   (mem_rdata)
  );

  AST_WRITE_AT_SP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we) |-> mem_addr == sp);                    // R2
  AST_READ_BELOW_SP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_we) |-> mem_addr == sp - SP_W'(STEP));     // R5
  AST_SP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> $stable(sp));                   // R7

endmodule

// File: tb/test_irq_frame_seq.sv
module test_irq_frame_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        entry_req = 1'b0;
  logic [3:0]  entry_level = '0;
  logic [22:0] entry_pc = '0;
  logic        ret_req = 1'b0;
  logic        sw_sr_we = 1'b0;
  logic [7:0]  sw_sr_data = '0;
  logic        busy, entry_done, ret_done, ipl3;
  logic [22:0] ret_pc;
  logic [7:0]  sr_low;
  logic [15:0] sp;
  logic        mem_valid, mem_ready, mem_we;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;

  int unsigned n_tests = 0;
  int unsigned n_fail  = 0;
  logic        stall_en = 1'b0;
  logic        tog = 1'b0;
  logic        rdy_man = 1'b1;
  logic [15:0] mem_model [256];
  int unsigned cyc = 0;

  always #2 clk = ~clk;

  irq_frame_seq i_irq_frame_seq (
    .clk(clk), .rst_n(rst_n), .entry_req(entry_req), .entry_level(entry_level),
    .entry_pc(entry_pc), .ret_req(ret_req), .sw_sr_we(sw_sr_we),
    .sw_sr_data(sw_sr_data), .busy(busy), .entry_done(entry_done),
    .ret_done(ret_done), .ret_pc(ret_pc), .sr_low(sr_low), .ipl3(ipl3),
    .sp(sp), .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  assign mem_ready = stall_en ? tog : rdy_man;
  assign mem_rdata = mem_model[mem_addr[8:1]];

  always @(negedge clk) tog <= ~tog;

  always @(posedge clk)
    if (mem_valid && mem_ready && mem_we) mem_model[mem_addr[8:1]] <= mem_wdata;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 50000) begin
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected<50000 cycles", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic sw_write(input logic [7:0] d);
    @(negedge clk);
    sw_sr_we = 1'b1;
    sw_sr_data = d;
    @(negedge clk);
    sw_sr_we = 1'b0;
  endtask

  task automatic wait_entry_done(output bit seen_ret);
    seen_ret = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (ret_done) seen_ret = 1'b1;
      if (entry_done) break;
    end
  endtask

  task automatic do_entry(input logic [22:0] pc, input logic [3:0] lvl);
    bit sr_flag;
    @(negedge clk);
    entry_req = 1'b1;
    entry_pc = pc;
    entry_level = lvl;
    @(negedge clk);
    entry_req = 1'b0;
    if (!entry_done) wait_entry_done(sr_flag);
  endtask

  task automatic do_return();
    @(negedge clk);
    ret_req = 1'b1;
    @(negedge clk);
    ret_req = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (ret_done) break;
      @(negedge clk);
    end
  endtask

  // {stall, pc[22:0], level[3:0], status byte[7:0]}
  localparam logic [35:0] VEC [4] = '{
    {1'b0, 23'h000123, 4'd3,  8'h01},
    {1'b1, 23'h7EDCBA, 4'd5,  8'h6A},
    {1'b0, 23'h400000, 4'd12, 8'hA5},
    {1'b1, 23'h00FFFF, 4'd7,  8'hE3}
  };

  initial begin
    logic        prev_ext;
    logic [15:0] base;
    bit          ret_seen;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(sp == 16'h0800, "R1 sp", 32'(sp), 32'h800);
    check(sr_low == 8'h00 && ipl3 == 1'b0, "R1 status", {sr_low, 7'b0, ipl3}, 0);
    check(!busy && !entry_done && !ret_done && !mem_valid, "R1 idle",
          {busy, entry_done, ret_done, mem_valid}, 0);

    // Table walk: nested entries (R2, R3, R4)
    prev_ext = 1'b0;
    for (int k = 0; k < 4; k++) begin
      stall_en = VEC[k][35];
      sw_write(VEC[k][7:0]);
      base = sp;
      do_entry(VEC[k][34:12], VEC[k][11:8]);
      check(entry_done && !busy, "R4 done pulse", {entry_done, busy}, 2'b10);
      check(sp == base + 16'd4, "R2 sp advance", 32'(sp), 32'(base + 16'd4));
      check(mem_model[base[8:1]] == VEC[k][27:12], "R2 word0 pc low",
            32'(mem_model[base[8:1]]), 32'(VEC[k][27:12]));
      check(mem_model[base[8:1] + 8'd1] == {VEC[k][7:0], prev_ext, VEC[k][34:28]},
            "R3 word1 layout", 32'(mem_model[base[8:1] + 8'd1]),
            32'({VEC[k][7:0], prev_ext, VEC[k][34:28]}));
      check(sr_low == {VEC[k][10:8], VEC[k][4:0]} && ipl3 == VEC[k][11],
            "R4 priority load", {ipl3, sr_low}, {VEC[k][11], VEC[k][10:8], VEC[k][4:0]});
      prev_ext = VEC[k][11];
      @(negedge clk);
      check(!entry_done, "R4 single pulse", 32'(entry_done), 0);
    end

    // Table walk: returns in reverse (R5, R6)
    for (int k = 3; k >= 0; k--) begin
      logic exp_ext;
      exp_ext = (k == 0) ? 1'b0 : VEC[k-1][11];
      stall_en = VEC[k][35];
      do_return();
      check(ret_done && ret_pc == VEC[k][34:12], "R5 ret_pc",
            32'(ret_pc), 32'(VEC[k][34:12]));
      check(sr_low == VEC[k][7:0] && ipl3 == exp_ext, "R6 status restore",
            {ipl3, sr_low}, {exp_ext, VEC[k][7:0]});
      check(sp == 16'h0800 + 16'(4 * k), "R5 sp fall", 32'(sp), 32'h800 + 32'(4 * k));
    end
    stall_en = 1'b0;

    // Directed: back-pressure, software write while busy, collision, ignored requests
    @(negedge clk);
    rdy_man = 1'b0;
    entry_req = 1'b1;
    entry_pc = 23'h2ABEEF;
    entry_level = 4'd6;
    @(negedge clk);
    entry_req = 1'b0;
    ret_req = 1'b1;
    entry_req = 1'b1;
    @(negedge clk);
    ret_req = 1'b0;
    entry_req = 1'b0;
    @(negedge clk);
    check(mem_valid && mem_we && mem_addr == 16'h0800 && mem_wdata == 16'hBEEF,
          "R7 held request", {mem_addr, mem_wdata}, {16'h0800, 16'hBEEF});
    check(sp == 16'h0800, "R7 sp frozen", 32'(sp), 32'h800);
    rdy_man = 1'b1;
    @(negedge clk);
    rdy_man = 1'b0;
    sw_sr_we = 1'b1;
    sw_sr_data = 8'h55;
    @(negedge clk);
    sw_sr_we = 1'b0;
    check(sr_low == 8'h55 && busy, "R8 write while busy", 32'(sr_low), 32'h55);
    @(negedge clk);
    rdy_man = 1'b1;
    sw_sr_we = 1'b1;
    sw_sr_data = 8'h1F;
    @(negedge clk);
    sw_sr_we = 1'b0;
    check(entry_done && sr_low == 8'hD5, "R8 load beats write", 32'(sr_low), 32'hD5);
    check(sp == 16'h0804, "R9 requests ignored while busy", 32'(sp), 32'h804);
    check(mem_model[1] == 16'h012A, "R3 snapshot at accept", 32'(mem_model[1]), 32'h012A);
    @(negedge clk);
    check(!busy, "R9 nothing queued", 32'(busy), 0);
    do_return();
    check(ret_pc == 23'h2ABEEF && sr_low == 8'h01 && sp == 16'h0800,
          "R5 directed return", {1'b0, ret_pc, sr_low}, {24'h2ABEEF, 8'h01});

    // Both requests in one idle cycle: entry wins (R9)
    @(negedge clk);
    entry_req = 1'b1;
    ret_req = 1'b1;
    entry_pc = 23'h011111;
    entry_level = 4'd1;
    @(negedge clk);
    entry_req = 1'b0;
    ret_req = 1'b0;
    wait_entry_done(ret_seen);
    check(entry_done && !ret_seen && sp == 16'h0804, "R9 entry wins",
          {ret_seen, sp}, 32'h0804);
    do_return();
    check(ret_pc == 23'h011111 && sp == 16'h0800, "R6 balanced stack",
          32'(ret_pc), 32'h011111);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule